// File: doc/BRIEF.md
# Vector Unit Reservation and Chaining Timer

This block keeps the issue timing for a group of fully pipelined vector functional units that share a file of vector registers. Each accepted instruction names one unit, a destination register, two source registers and a vector length (VL). The block reserves those registers for as long as the pipeline needs them. It opens a one-cycle chaining window on the destination when a consumer may start to use the stream of results. It also holds the chosen unit until that unit can take new operands. No arithmetic happens here. The block only decides when an instruction may go and which registers are in use.

The issue port follows valid/ready rules. `issue_ready` is computed from the register and unit state and from the offered fields, and it does not depend on `issue_valid`. An instruction is accepted on a rising edge where both are high. While it is not accepted, the requester must hold the fields steady. A held consumer that sets `chain_en` is accepted in the chaining cycle of the register it reads. Nothing is recorded for a cycle with no acceptance. Timing is counted in cycles after the acceptance edge: cycle 1 is the first cycle after that edge. Legal VL values are 1 to 64.

Unit codes on `unit_sel`: 0 integer add (3 stages), 1 narrow shift (3 stages), 2 wide shift (4 stages), 3 floating add (6 stages), 4 floating multiply (7 stages). Setup and shutdown each take 3 cycles.

Top module: `vrc_reserve_top`

## Requirements
- R1: After reset, `reg_busy` and `chain_open` are all zero, and an instruction offered with a legal unit code sees `issue_ready` high.
- R2: An accepted instruction holds `reg_busy[dst]` high for exactly n + VL + 5 cycles, cycles 1 to n + VL + 5, where n is the unit's stage count.
- R3: Each source register that is not also the destination holds `reg_busy` high for VL + 3 cycles after acceptance.
- R4: The stage counts are 3, 3, 4, 6 and 7 for unit codes 0, 1, 2, 3 and 4.
- R5: `chain_open[dst]` is high for exactly one cycle. That cycle is cycle 8, 8, 9, 11 or 12 after acceptance, for unit codes 0 to 4 in that order.
- R6: `issue_ready` is low while the destination is busy, or while a source is busy, except for a source whose `chain_open` is high in that cycle with `chain_en` set.
- R7: An accepted unit refuses a further instruction for VL + 3 cycles, and takes one again in cycle VL + 4.
- R8: When a consumer chains onto a register, that register stays busy for the longer of its remaining destination time and the consumer's VL + 3 source time. Its chaining window does not open again.
- R9: Unit codes 5, 6 and 7 are never accepted. Offering one leaves every register free.
- R10: `stall` is high exactly when `issue_valid` is high and `issue_ready` is low. A stalled instruction reserves nothing.
- R11: Instructions on different units with disjoint registers are accepted in consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| issue_valid | input | 1 | An instruction is offered |
| issue_ready | output | 1 | The offered instruction may be accepted this cycle |
| stall | output | 1 | Offered but refused this cycle |
| unit_sel | input | 3 | Functional unit code |
| dst_reg | input | 3 | Destination register number |
| src_a_reg | input | 3 | First source register number |
| src_b_reg | input | 3 | Second source register number |
| vec_len | input | 7 | Vector length, 1 to 64 |
| chain_en | input | 1 | The instruction may chain onto a busy source in its chaining cycle |
| reg_busy | output | 8 | Per-register reservation flags |
| chain_open | output | 8 | Per-register one-cycle chaining window |

## Verification
The tight case is a chaining acceptance that lands in the same cycle as a countdown. The chained register is reloaded as a source while its destination timer is still running. Directed runs hold a consumer with `chain_en` against a producer on each unit in turn. The expected acceptance cycle comes from the unit's chain slot. Long random runs with held, partly overlapping instructions make merges and expiries meet. Every cycle, the busy vector that follows is compared with a bench model that takes the longer of the two lengths.

// File: rtl/vrc_pkg.sv
package vrc_pkg;
  localparam int NUNIT      = 5;
  localparam int UNIT_W     = 3;
  localparam int MAX_STAGES = 7;

  typedef enum logic [UNIT_W-1:0] {
    FU_IADD = 3'd0,
    FU_SHN  = 3'd1,
    FU_SHW  = 3'd2,
    FU_FADD = 3'd3,
    FU_FMUL = 3'd4
  } fu_e;

  // pipeline depth of each unit
  function automatic int fu_stages(input logic [UNIT_W-1:0] u);
    case (u)
      FU_IADD: return 3;
      FU_SHN:  return 3;
      FU_SHW:  return 4;
      FU_FADD: return 6;
      FU_FMUL: return 7;
      default: return 0;
    endcase
  endfunction

  // cycle after issue in which a consumer may chain
  function automatic int fu_chain_slot(input logic [UNIT_W-1:0] u);
    case (u)
      FU_IADD: return 8;
      FU_SHN:  return 8;
      FU_SHW:  return 9;
      FU_FADD: return 11;
      FU_FMUL: return 12;
      default: return 1;
    endcase
  endfunction
endpackage

// File: rtl/vrc_reg_timer.sv
module vrc_reg_timer #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_dst,
  input  logic             ld_src,
  input  logic [CNT_W-1:0] dst_len,
  input  logic [CNT_W-1:0] src_len,
  input  logic [CNT_W-1:0] chain_at,
  output logic             busy,
  output logic             chain_open
);
  logic [CNT_W-1:0] rem, cat, dec, merged;
  logic             is_dst;

  assign dec    = (rem == '0) ? '0 : rem - 1'b1;
  // a chained source keeps the longer of the two reservations
  assign merged = (src_len > dec) ? src_len : dec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem    <= '0;
      cat    <= '0;
      is_dst <= 1'b0;
    end else if (ld_dst) begin
      rem    <= dst_len;
      cat    <= chain_at;
      is_dst <= 1'b1;
    end else if (ld_src) begin
      rem    <= merged;
      is_dst <= 1'b0;
    end else begin
      rem    <= dec;
    end
  end

  assign busy       = (rem != '0);
  assign chain_open = is_dst && (rem == cat) && busy;
endmodule

// File: rtl/vrc_unit_timer.sv
module vrc_unit_timer #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld,
  input  logic [CNT_W-1:0] len,
  output logic             busy
);
  logic [CNT_W-1:0] rem;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          rem <= '0;
    else if (ld)         rem <= len;
    else if (rem != '0)  rem <= rem - 1'b1;
  end

  assign busy = (rem != '0);
endmodule

// File: rtl/vrc_issue_ctrl.sv
module vrc_issue_ctrl
  import vrc_pkg::*;
#(
  parameter int NREG      = 8,
  parameter int REG_W     = 3,
  parameter int VL_W      = 7,
  parameter int CNT_W     = 7,
  parameter int SETUP_CYC = 3,
  parameter int SHUT_CYC  = 3
) (
  input  logic              issue_valid,
  input  logic [UNIT_W-1:0] unit_sel,
  input  logic [REG_W-1:0]  dst_reg,
  input  logic [REG_W-1:0]  src_a_reg,
  input  logic [REG_W-1:0]  src_b_reg,
  input  logic [VL_W-1:0]   vec_len,
  input  logic              chain_en,
  input  logic [NREG-1:0]   reg_busy,
  input  logic [NREG-1:0]   chain_open,
  input  logic [NUNIT-1:0]  unit_busy,
  output logic              issue_ready,
  output logic              fire,
  output logic [CNT_W-1:0]  dst_len,
  output logic [CNT_W-1:0]  src_len,
  output logic [CNT_W-1:0]  chain_at
);
  logic unit_known, unit_held, a_ok, b_ok;
  int   stages, slot;

  always_comb begin
    unit_known = 1'b0;
    unit_held  = 1'b0;
    for (int u = 0; u < NUNIT; u++) begin
      if (unit_sel == UNIT_W'(u)) begin
        unit_known = 1'b1;
        unit_held  = unit_busy[u];
      end
    end
  end

  assign stages = fu_stages(unit_sel);
  assign slot   = fu_chain_slot(unit_sel);

  assign a_ok = !reg_busy[src_a_reg] || (chain_en && chain_open[src_a_reg]);
  assign b_ok = !reg_busy[src_b_reg] || (chain_en && chain_open[src_b_reg]);

  assign issue_ready = unit_known && !unit_held && !reg_busy[dst_reg] && a_ok && b_ok;
  assign fire        = issue_valid && issue_ready;

  assign dst_len  = CNT_W'(SETUP_CYC + stages + int'(vec_len) - 1 + SHUT_CYC);
  assign src_len  = CNT_W'(SETUP_CYC + int'(vec_len));
  assign chain_at = CNT_W'(SETUP_CYC + stages + int'(vec_len) + SHUT_CYC - slot);
endmodule

// File: rtl/vrc_reserve_top.sv
module vrc_reserve_top
  import vrc_pkg::*;
#(
  parameter int NREG      = 8,
  parameter int MAX_VL    = 64,
  parameter int SETUP_CYC = 3,
  parameter int SHUT_CYC  = 3,
  localparam int REG_W    = $clog2(NREG),
  localparam int VL_W     = $clog2(MAX_VL + 1),
  localparam int CNT_W    = $clog2(MAX_VL + MAX_STAGES + SETUP_CYC + SHUT_CYC + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_valid,
  output logic              issue_ready,
  output logic              stall,
  input  logic [UNIT_W-1:0] unit_sel,
  input  logic [REG_W-1:0]  dst_reg,
  input  logic [REG_W-1:0]  src_a_reg,
  input  logic [REG_W-1:0]  src_b_reg,
  input  logic [VL_W-1:0]   vec_len,
  input  logic              chain_en,
  output logic [NREG-1:0]   reg_busy,
  output logic [NREG-1:0]   chain_open
);
  logic             fire;
  logic [CNT_W-1:0] dst_len, src_len, chain_at;
  logic [NUNIT-1:0] unit_busy;

  vrc_issue_ctrl #(
    .NREG(NREG), .REG_W(REG_W), .VL_W(VL_W), .CNT_W(CNT_W),
    .SETUP_CYC(SETUP_CYC), .SHUT_CYC(SHUT_CYC)
  ) u_ctrl (
    .issue_valid(issue_valid), .unit_sel(unit_sel), .dst_reg(dst_reg),
    .src_a_reg(src_a_reg), .src_b_reg(src_b_reg), .vec_len(vec_len),
    .chain_en(chain_en), .reg_busy(reg_busy), .chain_open(chain_open),
    .unit_busy(unit_busy), .issue_ready(issue_ready), .fire(fire),
    .dst_len(dst_len), .src_len(src_len), .chain_at(chain_at)
  );

  assign stall = issue_valid && !issue_ready;

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    logic ld_dst, ld_src;
    assign ld_dst = fire && (dst_reg == REG_W'(r));
    assign ld_src = fire && ((src_a_reg == REG_W'(r)) || (src_b_reg == REG_W'(r)));
    vrc_reg_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk(clk), .rst_n(rst_n), .ld_dst(ld_dst), .ld_src(ld_src),
      .dst_len(dst_len), .src_len(src_len), .chain_at(chain_at),
      .busy(reg_busy[r]), .chain_open(chain_open[r])
    );
  end

  for (genvar u = 0; u < NUNIT; u++) begin : g_unit
    logic ld;
    assign ld = fire && (unit_sel == UNIT_W'(u));
    vrc_unit_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk(clk), .rst_n(rst_n), .ld(ld), .len(src_len), .busy(unit_busy[u])
    );
  end
endmodule

// File: rtl/vrc_reserve_chk.sv
module vrc_reserve_chk
  import vrc_pkg::*;
#(
  parameter int NREG  = 8,
  parameter int REG_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              issue_valid,
  input logic              issue_ready,
  input logic [UNIT_W-1:0] unit_sel,
  input logic [REG_W-1:0]  dst_reg,
  input logic [REG_W-1:0]  src_a_reg,
  input logic [REG_W-1:0]  src_b_reg,
  input logic [NREG-1:0]   reg_busy,
  input logic [NREG-1:0]   chain_open
);
  logic acc;
  assign acc = issue_valid && issue_ready;

  a_r2_dst_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> reg_busy[$past(dst_reg)]);

  a_r3_src_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (reg_busy[$past(src_a_reg)] && reg_busy[$past(src_b_reg)]));

  a_r6_free_dst: assert property (@(posedge clk) disable iff (!rst_n)
    acc |-> !reg_busy[dst_reg]);

  a_r7_unit_held: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> !(unit_sel == $past(unit_sel) && issue_ready));

  a_r9_bad_unit: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_sel >= UNIT_W'(NUNIT)) |-> !issue_ready);

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    a_r5_chain_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      chain_open[i] |=> !chain_open[i]);
    a_r5_chain_on_busy: assert property (@(posedge clk) disable iff (!rst_n)
      chain_open[i] |-> reg_busy[i]);
  end
endmodule

bind vrc_reserve_top vrc_reserve_chk #(.NREG(NREG), .REG_W(REG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_ready(issue_ready),
  .unit_sel(unit_sel), .dst_reg(dst_reg), .src_a_reg(src_a_reg),
  .src_b_reg(src_b_reg), .reg_busy(reg_busy), .chain_open(chain_open)
);

// File: tb/test_vrc_reserve_top.sv
`timescale 1ns/1ps
module test_vrc_reserve_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       issue_valid = 1'b0;
  logic       issue_ready, stall;
  logic [2:0] unit_sel = '0, dst_reg = '0, src_a_reg = '0, src_b_reg = '0;
  logic [6:0] vec_len = 7'd1;
  logic       chain_en = 1'b0;
  logic [7:0] reg_busy, chain_open;

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  // bench model state
  int m_rem[8], m_cat[8], m_ub[5];
  bit m_isd[8];
  logic [7:0] s_busy, s_chain;

  always #2 clk = ~clk;

  vrc_reserve_top i_vrc_reserve_top (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_ready(issue_ready),
    .stall(stall), .unit_sel(unit_sel), .dst_reg(dst_reg), .src_a_reg(src_a_reg),
    .src_b_reg(src_b_reg), .vec_len(vec_len), .chain_en(chain_en),
    .reg_busy(reg_busy), .chain_open(chain_open)
  );

  function automatic int stg(int u);
    case (u) 0: return 3; 1: return 3; 2: return 4; 3: return 6; 4: return 7; default: return 0; endcase
  endfunction
  function automatic int slot(int u);
    case (u) 0: return 8; 1: return 8; 2: return 9; 3: return 11; 4: return 12; default: return 1; endcase
  endfunction
  function automatic bit m_chain(int r);
    return m_isd[r] && m_rem[r] != 0 && m_rem[r] == m_cat[r];
  endfunction
  function automatic bit m_ok(int u, int d, int a, int b, bit ce);
    if (u > 4 || m_ub[u] != 0 || m_rem[d] != 0) return 0;
    if (m_rem[a] != 0 && !(ce && m_chain(a))) return 0;
    if (m_rem[b] != 0 && !(ce && m_chain(b))) return 0;
    return 1;
  endfunction

  task automatic chk(bit good, string req, string what, int act, int exp);
    n_checks++;
    if (!good) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic model_step(bit f, int u, int d, int a, int b, int l);
    for (int r = 0; r < 8; r++) begin
      int dec = (m_rem[r] == 0) ? 0 : m_rem[r] - 1;
      if (f && r == d) begin
        m_rem[r] = stg(u) + l + 5;
        m_cat[r] = l + stg(u) + 6 - slot(u);
        m_isd[r] = 1;
      end else if (f && (r == a || r == b)) begin
        m_rem[r] = (l + 3 > dec) ? l + 3 : dec;
        m_isd[r] = 0;
      end else m_rem[r] = dec;
    end
    for (int x = 0; x < 5; x++)
      if (f && x == u) m_ub[x] = l + 3;
      else if (m_ub[x] != 0) m_ub[x]--;
  endtask

  // one cycle: drive, sample, compare against the model, advance the model
  task automatic cyc(bit v, int u, int d, int a, int b, int l, bit ce, output bit fired);
    logic [7:0] eb, ec;
    bit eok;
    @(negedge clk);
    issue_valid = v; unit_sel = 3'(u); dst_reg = 3'(d); src_a_reg = 3'(a);
    src_b_reg = 3'(b); vec_len = 7'(l); chain_en = ce;
    #1;
    s_busy = reg_busy; s_chain = chain_open;
    for (int r = 0; r < 8; r++) begin eb[r] = (m_rem[r] != 0); ec[r] = m_chain(r); end
    eok = m_ok(u, d, a, b, ce);
    chk(reg_busy === eb, "R2 R3 R8", "reg_busy", reg_busy, eb);
    chk(chain_open === ec, "R5", "chain_open", chain_open, ec);
    chk(issue_ready === eok, "R6 R7 R9", "issue_ready", issue_ready, eok);
    chk(stall === (v && !eok), "R10", "stall", stall, v && !eok);
    fired = v && eok;
    model_step(fired, u, d, a, b, l);
  endtask

  task automatic idle(int n);
    bit f;
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 1, 0, f);
  endtask

  // hold one instruction until accepted; k = acceptance cycle, cf = first chain_open on creg
  task automatic hold(int u, int d, int a, int b, int l, bit ce, int maxk, int creg,
                      output int k, output int cf);
    bit f;
    k = 0; cf = 0;
    for (int i = 1; i <= maxk; i++) begin
      cyc(1, u, d, a, b, l, ce, f);
      if (s_chain[creg] && cf == 0) cf = i;
      if (f) begin k = i; break; end
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    bit f;
    int k, cf, cnt, cnt2;
    for (int r = 0; r < 8; r++) begin m_rem[r] = 0; m_cat[r] = 0; m_isd[r] = 0; end
    for (int x = 0; x < 5; x++) m_ub[x] = 0;
    void'($urandom(32'h5EED_0017));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    @(negedge clk); issue_valid = 1; unit_sel = 0; dst_reg = 1; src_a_reg = 2; src_b_reg = 3;
    #1;
    chk(reg_busy === 8'h00, "R1", "busy after reset", reg_busy, 0);
    chk(chain_open === 8'h00, "R1", "chain after reset", chain_open, 0);
    chk(issue_ready === 1'b1, "R1", "ready after reset", issue_ready, 1);
    issue_valid = 0;

    // R2 R4 R3: floating add, VL 5 -> dst 16 cycles, source 8 cycles
    cyc(1, 3, 1, 2, 3, 5, 0, f);
    chk(f, "R2", "fadd accepted", f, 1);
    cnt = 0; cnt2 = 0;
    for (int i = 0; i < 30; i++) begin
      cyc(0, 0, 0, 0, 0, 1, 0, f);
      cnt += s_busy[1]; cnt2 += s_busy[2];
    end
    chk(cnt == 16, "R2 R4", "dst busy cycles", cnt, 16);
    chk(cnt2 == 8, "R3", "src busy cycles", cnt2, 8);

    // R5 R6 R8: chain slot on every unit
    for (int u = 0; u < 5; u++) begin
      idle(90);
      cyc(1, u, 0, 6, 7, 3, 0, f);
      hold((u + 1) % 5, 4, 0, 5, 6, 1, 40, 0, k, cf);
      chk(k == slot(u), "R5 R6", "chain accept cycle", k, slot(u));
      chk(cf == slot(u), "R5", "chain window cycle", cf, slot(u));
      cyc(0, 0, 0, 0, 0, 1, 0, f);
      chk(s_busy[0] == 1'b1, "R8", "chained reg still busy", s_busy[0], 1);
    end

    // R6 R10: no chain_en -> waits for full release (shift, VL 4 -> 12 cycles)
    idle(90);
    cyc(1, 1, 0, 1, 2, 4, 0, f);
    cnt = 0;
    for (int i = 1; i <= 30; i++) begin
      cyc(1, 0, 4, 0, 5, 2, 0, f);
      if (!f && s_busy[4]) cnt++;
      if (f) begin k = i; break; end
    end
    chk(k == 13, "R6", "unchained accept cycle", k, 13);
    chk(cnt == 0, "R10", "stalled reserves nothing", cnt, 0);

    // R11 then R7: other unit next cycle, same unit after VL+3
    idle(90);
    cyc(1, 0, 0, 1, 2, 2, 0, f);
    hold(3, 6, 7, 7, 2, 0, 20, 0, k, cf);
    chk(k == 1, "R11", "other unit back to back", k, 1);
    idle(90);
    cyc(1, 0, 0, 1, 2, 2, 0, f);
    hold(0, 3, 4, 5, 2, 0, 20, 0, k, cf);
    chk(k == 6, "R7", "same unit reaccept cycle", k, 6);

    // R9: unknown unit codes
    idle(90);
    for (int u = 5; u < 8; u++) begin
      cyc(1, u, 1, 2, 3, 4, 0, f);
      chk(!f, "R9", "bad unit accepted", f, 0);
    end
    cyc(0, 0, 0, 0, 0, 1, 0, f);
    chk(s_busy == 8'h00, "R9", "busy after bad unit", s_busy, 0);

    // random: held instructions, short and full vector lengths
    for (int n = 0; n < 1500; n++) begin
      int u = $urandom % 6;
      int l = ($urandom % 8 == 0) ? 64 : ($urandom % 8) + 1;
      hold(u, $urandom % 8, $urandom % 8, $urandom % 8, l, $urandom % 2, 40, 0, k, cf);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule